// File: doc/BRIEF.md
# Sample Takeout Read-Zero Sequencer

This block fetches one companded audio byte from a main-memory buffer slot, expands it to a linear sample through an external lookup PROM, and leaves that slot cleared. The cleared slot can then take later audio that is summed into it. A takeout is launched with a single-cycle start pulse and the slot address. The sequencer then runs exactly two memory cycles at that address. The first is a read. The second is a write of zero.

A single complementing phase flop drives the PROM's least significant address bit. The companded byte drives the PROM's upper address bits. In the first cycle that byte comes straight from the memory read data. It is also captured into a holding register, and the holding register supplies it in the second cycle. So the two PROM lookups reach adjacent entries. The same phase flop turns the second memory cycle into the zero write. Each memory cycle lasts until the memory raises its acknowledge. The two PROM bytes are joined into one 16-bit linear word, which is delivered with a one-cycle valid strobe.

Top module: `sample_takeout_seq`

## Requirements
- R1: During and after reset, `mem_req`, `lin_valid` and `busy` are 0.
- R2: Each takeout makes exactly one acknowledged read memory cycle (`mem_we`=0), followed by exactly one acknowledged write memory cycle (`mem_we`=1).
- R3: `prom_addr[0]` carries the phase: 0 during the read cycle and 1 during the write cycle. `prom_addr[8:1]` carries the companded byte.
- R4: During the write cycle, `prom_addr[8:1]` holds the byte returned by the read, whatever `mem_rdata` shows during the write.
- R5: The write cycle drives `mem_wdata` = 0, so the slot reads back as zero afterwards.
- R6: Both memory cycles of a takeout use the `start_addr` that was sampled when the start pulse was accepted.
- R7: One cycle after the write is acknowledged, `lin_valid` is 1 for exactly one cycle. At that point `lin_data[15:8]` is the PROM byte at phase 0 and `lin_data[7:0]` is the PROM byte at phase 1.
- R8: The phase flop returns to 0 at the start of every takeout, so every read cycle presents phase 0.
- R9: While `mem_ack` is low, the request is held: `mem_req`, `mem_we` and `mem_addr` keep their values into the next cycle.
- R10: A start pulse that arrives while `busy` is 1 is ignored. The running takeout finishes at its own address, and no extra memory cycle or result follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start-of-takeout pulse |
| start_addr | input | ADDR_W | Buffer slot address |
| busy | output | 1 | A takeout is in progress |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | 1 = write cycle, 0 = read cycle |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | BYTE_W | Write data (always zero) |
| mem_rdata | input | BYTE_W | Read data, valid while acknowledged |
| mem_ack | input | 1 | Memory ready/grant; completes the cycle |
| prom_addr | output | BYTE_W+1 | PROM address {byte, phase} |
| prom_data | input | BYTE_W | PROM data, combinational from prom_addr |
| lin_data | output | 2*BYTE_W | Linear sample |
| lin_valid | output | 1 | One-cycle strobe for lin_data |

## Verification
The bench builds the block with ADDR_W=6, BYTE_W=8 and HI_FIRST=1. With only 64 slots, the memory model can hold the whole buffer, and the bench can confirm that only the addressed slot was cleared. With ADDR_W=6 the bench can also revisit a slot to check that the second result decodes a zero byte. Acknowledge latencies of 0, 1 and 3 cycles exercise both single-cycle completion and held requests. During write cycles the memory model drives nonzero junk on the read data, so a PROM lookup that falls back to the live read bus is exposed.

// File: rtl/stk_pkg.sv
package stk_pkg;
   typedef enum logic [1:0] {
      STK_IDLE  = 2'd0,
      STK_FETCH = 2'd1,
      STK_CLEAR = 2'd2
   } stk_state_e;
endpackage

// File: rtl/stk_toggle.sv
module stk_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic flip,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)     q <= 1'b0;
      else if (clear) q <= 1'b0;
      else if (flip)  q <= ~q;
   end

   // R8
   phase_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !q);
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              mem_ack,
   output stk_pkg::stk_state_e state,
   output logic              begin_take,
   output logic              rd_done,
   output logic              wr_done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] addr_q
);
   import stk_pkg::*;

   stk_state_e state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= STK_IDLE;
         addr_q  <= '0;
      end else begin
         unique case (state_q)
            STK_IDLE: if (start) begin
               state_q <= STK_FETCH;
               addr_q  <= start_addr;
            end
            STK_FETCH: if (mem_ack) state_q <= STK_CLEAR;
            STK_CLEAR: if (mem_ack) state_q <= STK_IDLE;
            default:   state_q <= STK_IDLE;
         endcase
      end
   end

   always_comb begin
      state      = state_q;
      begin_take = (state_q == STK_IDLE) && start;
      mem_req    = (state_q == STK_FETCH) || (state_q == STK_CLEAR);
      mem_we     = (state_q == STK_CLEAR);
      rd_done    = (state_q == STK_FETCH) && mem_ack;
      wr_done    = (state_q == STK_CLEAR) && mem_ack;
   end

   // R2
   read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> (mem_req && mem_we));
   // R10
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !wr_done) |=> $stable(addr_q));
endmodule

// File: rtl/stk_assemble.sv
module stk_assemble #(
   parameter int BYTE_W   = 8,
   parameter bit HI_FIRST = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap_first,
   input  logic                cap_second,
   input  logic [BYTE_W-1:0]   prom_data,
   output logic [2*BYTE_W-1:0] lin_data,
   output logic                lin_valid
);
   logic [BYTE_W-1:0]   first_q;
   logic [2*BYTE_W-1:0] joined;

   generate
      if (HI_FIRST) begin : g_hi_first
         assign joined = {first_q, prom_data};
      end else begin : g_lo_first
         assign joined = {prom_data, first_q};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_q   <= '0;
         lin_data  <= '0;
         lin_valid <= 1'b0;
      end else begin
         if (cap_first) first_q <= prom_data;
         if (cap_second) lin_data <= joined;
         lin_valid <= cap_second;
      end
   end

   // R7
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lin_valid |=> !lin_valid);
endmodule

// File: rtl/sample_takeout_seq.sv
module sample_takeout_seq #(
   parameter int ADDR_W   = 16,
   parameter int BYTE_W   = 8,
   parameter bit HI_FIRST = 1'b1,
   localparam int PA_W    = BYTE_W + 1,
   localparam int LIN_W   = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   output logic              busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   input  logic [BYTE_W-1:0] mem_rdata,
   input  logic              mem_ack,
   output logic [PA_W-1:0]   prom_addr,
   input  logic [BYTE_W-1:0] prom_data,
   output logic [LIN_W-1:0]  lin_data,
   output logic              lin_valid
);
   import stk_pkg::*;

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
      if (BYTE_W < 2) begin : g_bad_byte
         $error("BYTE_W must be at least 2");
      end
   endgenerate

   stk_state_e          state;
   logic                begin_take, rd_done, wr_done, phase_q;
   logic [BYTE_W-1:0]   byte_q, byte_sel;

   stk_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .mem_ack(mem_ack), .state(state), .begin_take(begin_take),
      .rd_done(rd_done), .wr_done(wr_done), .mem_req(mem_req),
      .mem_we(mem_we), .addr_q(mem_addr)
   );

   stk_toggle u_phase (
      .clk(clk), .rst_n(rst_n), .clear(begin_take),
      .flip(mem_req && mem_ack), .q(phase_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       byte_q <= '0;
      else if (rd_done) byte_q <= mem_rdata;
   end

   assign byte_sel  = (state == STK_FETCH) ? mem_rdata : byte_q;
   assign prom_addr = {byte_sel, phase_q};
   assign mem_wdata = '0;
   assign busy      = mem_req;

   stk_assemble #(.BYTE_W(BYTE_W), .HI_FIRST(HI_FIRST)) u_asm (
      .clk(clk), .rst_n(rst_n), .cap_first(rd_done), .cap_second(wr_done),
      .prom_data(prom_data), .lin_data(lin_data), .lin_valid(lin_valid)
   );

   // R3
   phase_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> !prom_addr[0]);
   // R3
   phase_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> prom_addr[0]);
   // R4
   held_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && !mem_ack) |=> $stable(prom_addr));
   // R5
   zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_wdata == '0));
   // R6
   same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && !mem_we) |=> (mem_req && mem_we && $stable(mem_addr)));
   // R9
   hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));
   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (!mem_req && !lin_valid && !busy));
endmodule

// File: tb/sample_takeout_seq_tb.sv
module sample_takeout_seq_tb;
   localparam int AW = 6;
   localparam int BW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic busy, mem_req, mem_we, mem_ack, lin_valid;
   logic [AW-1:0] mem_addr;
   logic [BW-1:0] mem_wdata, mem_rdata, prom_data;
   logic [BW:0]   prom_addr;
   logic [2*BW-1:0] lin_data;

   always #2 clk = ~clk;

   int checks = 0, failures = 0, cycles = 0;
   int wait_cfg = 0, wcnt = 0;
   int rd_cnt = 0, wr_cnt = 0, results = 0;
   logic [AW-1:0] exp_addr;
   logic [BW-1:0] exp_byte;
   logic [2*BW-1:0] exp_q[$];
   logic [BW-1:0] mem [64];

   function automatic logic [BW-1:0] prom_f(logic [BW:0] a);
      return 8'((a * 29) ^ (a >> 2) ^ 9'h03C);
   endfunction

   function automatic logic [BW-1:0] init_f(int i);
      return 8'(i * 7 + 3);
   endfunction

   sample_takeout_seq #(.ADDR_W(AW), .BYTE_W(BW), .HI_FIRST(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .prom_addr(prom_addr), .prom_data(prom_data), .lin_data(lin_data),
      .lin_valid(lin_valid)
   );

   assign prom_data = prom_f(prom_addr);
   assign mem_ack   = mem_req && (wcnt == wait_cfg);
   assign mem_rdata = (mem_req && !mem_we) ? mem[mem_addr] : 8'hC3;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem[i] <= init_f(i);
         wcnt <= 0;
      end else if (mem_req) begin
         if (wcnt == wait_cfg) begin
            wcnt <= 0;
            if (mem_we) mem[mem_addr] <= mem_wdata;
         end else wcnt <= wcnt + 1;
      end else wcnt <= 0;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   logic [AW-1:0] last_addr;
   logic          last_we, last_req;

   // monitor: bus cycles and scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         cycles++;
         if (last_req && !mem_ack) ;
         if (mem_req && mem_ack) begin
            if (!mem_we) begin
               rd_cnt++;
               chk(prom_addr == {exp_byte, 1'b0}, "R8 R3 read prom_addr", 32'(prom_addr), 32'({exp_byte, 1'b0}));
            end else begin
               wr_cnt++;
               chk(prom_addr == {exp_byte, 1'b1}, "R4 R3 write prom_addr", 32'(prom_addr), 32'({exp_byte, 1'b1}));
               chk(mem_wdata == 0, "R5 write data", 32'(mem_wdata), 0);
            end
            chk(mem_addr == exp_addr, "R6 address", 32'(mem_addr), 32'(exp_addr));
         end
         // R9: held request keeps address and direction
         if (last_req && !mem_ack && wcnt != 0)
            chk(mem_req && mem_we == last_we && mem_addr == last_addr,
                "R9 hold", 32'(mem_addr), 32'(last_addr));
         if (lin_valid) begin
            if (exp_q.size() == 0) chk(0, "R10 unexpected result", 32'(lin_data), 0);
            else begin
               logic [2*BW-1:0] e;
               e = exp_q.pop_front();
               chk(lin_data == e, "R7 lin_data", 32'(lin_data), 32'(e));
            end
            chk(rd_cnt == 1 && wr_cnt == 1, "R2 cycle count", 32'(rd_cnt*16+wr_cnt), 32'h11);
            rd_cnt = 0; wr_cnt = 0;
            results++;
         end
         last_req = mem_req && !mem_ack;
         last_we = mem_we; last_addr = mem_addr;
      end
      if (cycles > 100000) begin
         chk(0, "watchdog", 32'(cycles), 0);
         finish_run();
      end
   end

   task automatic takeout(input logic [AW-1:0] a, input int waits);
      int target;
      @(negedge clk);
      wait_cfg = waits;
      exp_addr = a;
      exp_byte = mem[a];
      exp_q.push_back({prom_f({mem[a], 1'b0}), prom_f({mem[a], 1'b1})});
      target = results + 1;
      start = 1'b1; start_addr = a;
      @(negedge clk);
      start = 1'b0;
      wait (results == target);
      @(negedge clk);
      chk(mem[a] == 0, "R5 slot cleared", 32'(mem[a]), 0);
      chk(!busy && !mem_req, "R2 idle after takeout", 32'(busy), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!mem_req && !lin_valid && !busy, "R1 reset outputs",
          32'({mem_req, lin_valid, busy}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!mem_req && !busy, "R1 idle after reset", 32'(busy), 0);

      takeout(6'd5, 0);
      takeout(6'd17, 1);
      takeout(6'd63, 3);
      takeout(6'd0, 0);
      // revisit cleared slot: result decodes byte zero (R5, R7)
      takeout(6'd17, 2);
      chk(mem[18] == init_f(18), "R5 neighbour untouched", 32'(mem[18]), 32'(init_f(18)));

      // R10: start while busy is ignored
      begin
         int target;
         @(negedge clk);
         wait_cfg = 3;
         exp_addr = 6'd40; exp_byte = mem[40];
         exp_q.push_back({prom_f({mem[40], 1'b0}), prom_f({mem[40], 1'b1})});
         target = results + 1;
         start = 1'b1; start_addr = 6'd40;
         @(negedge clk);
         start = 1'b0;
         @(negedge clk);
         chk(busy, "R10 busy during takeout", 32'(busy), 1);
         start = 1'b1; start_addr = 6'd41;
         @(negedge clk);
         start = 1'b0;
         wait (results == target);
         repeat (12) @(negedge clk);
         chk(results == target, "R10 no extra result", 32'(results), 32'(target));
         chk(mem[41] == init_f(41), "R10 second slot untouched", 32'(mem[41]), 32'(init_f(41)));
         chk(mem[40] == 0, "R10 first slot cleared", 32'(mem[40]), 0);
      end

      takeout(6'd33, 1);
      chk(exp_q.size() == 0, "R7 scoreboard drained", 32'(exp_q.size()), 0);
      finish_run();
   end
endmodule